// File: doc/BRIEF.md
# Rank Refresh Sequencer

This block schedules and carries out periodic refresh for a single DRAM rank. It keeps the time at which the next refresh falls due. A little before that time it claims the rank, and wakes it first if the rank is in a low-power state. It then waits for outstanding requests to finish and closes any open banks with a precharge-all command. Only then does it issue the refresh. While the refresh runs it holds the rank busy, and it publishes a new earliest-activate time that applies to every bank.

Time is supplied by the surrounding controller as a free-running cycle count, `cur_time`, which must advance by one each clock. An event "happens at time T" when it is registered at the clock edge where `cur_time` equals T. Its output pulse is then visible for the one clock period after that edge. Timing parameters are in cycles: `T_RP` is the precharge time, `T_RFC` the refresh duration, `T_REFI` the refresh interval and `T_XP` the power-down exit delay. Bank `i`'s earliest-precharge time sits at bits `[i*TW +: TW]` of `bank_pre_ok`.

Top module: `rank_refresh_seq`

## Requirements
- R1: During and after reset, `wake_req`, `prea_cmd`, `ref_cmd`, `act_floor_upd`, `rank_busy` and `overrun_err` are 0, and the refresh-due time is initialised to `T_REFI`.
- R2: When idle, a refresh sequence starts at the first edge where `cur_time >= due - T_RP`, and `rank_busy` becomes 1 at that edge.
- R3: If `low_power` is 1 when a sequence starts, one `wake_req` pulse is issued at the start time, and the drain check is not made until `T_XP` cycles later. The first drain check then happens at start + `T_XP` + 1.
- R4: No precharge or refresh is issued while `drain_done` is 0. The sequence waits in the drain phase.
- R5: When `active_banks` is nonzero at the drain check, `prea_cmd` is issued at the later of the drain-check time and the largest per-bank earliest-precharge time.
- R6: With a precharge-all at time P, `act_floor` becomes P + `T_RP` with an `act_floor_upd` pulse at P, and the refresh is issued at P + `T_RP`.
- R7: When `active_banks` is 0 at the drain check, the refresh is issued at that same time and no `prea_cmd` is issued.
- R8: With a refresh at time F, `act_floor` becomes F + `T_RFC` with an `act_floor_upd` pulse at F. `rank_busy` stays 1 until the edge where `cur_time` reaches F + `T_RFC`, where it returns to 0.
- R9: Each refresh advances the due time by `T_REFI`, so the next sequence starts at the new due time minus `T_RP`.
- R10: If the advanced due time is earlier than the end of the refresh just issued, `overrun_err` is set and stays set until reset.
- R11: `cfg_err` is 1 exactly when `T_REFI <= T_RP` or `T_REFI <= T_RFC`.
- R12: `wake_req`, `prea_cmd` and `ref_cmd` are one-cycle pulses, never two in the same cycle, and each is issued only while `rank_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_time | input | TW | Free-running cycle count |
| active_banks | input | BCW | Number of banks currently open |
| bank_pre_ok | input | NB*TW | Per-bank earliest precharge time, bank i at [i*TW +: TW] |
| low_power | input | 1 | Rank is in a low-power state |
| drain_done | input | 1 | No requests for this rank are in flight |
| wake_req | output | 1 | Pulse: request power-down exit |
| prea_cmd | output | 1 | Pulse: precharge all banks |
| ref_cmd | output | 1 | Pulse: refresh command |
| act_floor | output | TW | Earliest activate time for all banks |
| act_floor_upd | output | 1 | Pulse: act_floor has a new value |
| rank_busy | output | 1 | Rank claimed by refresh; activates are blocked |
| overrun_err | output | 1 | Sticky: refresh fell behind its schedule |
| cfg_err | output | 1 | Timing parameters are inconsistent |

## Verification
Several rules are checked by properties on every cycle:
- command pulses are exclusive and last one cycle;
- commands appear only under `rank_busy`;
- the busy flag survives the cycle after a refresh;
- the overrun flag is sticky;
- the published activate floor never lies in the past when a refresh is issued.

The exact issue times can only be shown by the scenarios. Those cover the precharge time taken from the latest bank, immediate precharge, the wake-up delay, a held-off drain, the due-time advance and an overrun. The scenarios compare every command pulse and floor value against a predicted schedule.

// File: rtl/rfs_pkg.sv
// Package: shared types of the rank refresh sequencer.
// Assumes nothing beyond the phase list used by the control FSM.
package rfs_pkg;

    // Sequencer phases: idle, waking, draining, precharge wait,
    // precharge settle, refresh running.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_WAKE   = 3'd1,
        PH_DRAIN  = 3'd2,
        PH_PRE    = 3'd3,
        PH_SETTLE = 3'd4,
        PH_RUN    = 3'd5
    } rfs_phase_e;

endpackage

// File: rtl/rfs_latest_time.sv
// Module: rfs_latest_time
// Reduces NB packed per-bank times to their maximum, as a compare chain.
// Assumes times do not wrap inside the range of interest.
module rfs_latest_time #(
    parameter int TW = 32,
    parameter int NB = 8
) (
    input  logic [NB*TW-1:0] times,
    output logic [TW-1:0]    latest
);

    logic [TW-1:0] chain [NB];

    assign chain[0] = times[TW-1:0];

    // Each stage keeps the larger of the running maximum and its bank.
    for (genvar g = 1; g < NB; g++) begin : g_stage
        assign chain[g] = (times[g*TW +: TW] > chain[g-1]) ? times[g*TW +: TW]
                                                            : chain[g-1];
    end

    assign latest = chain[NB-1];

endmodule

// File: rtl/rfs_due_tracker.sv
// Module: rfs_due_tracker
// Holds the refresh-due time, raises the start hint T_RP ahead of it,
// advances it by T_REFI per refresh and flags a schedule overrun.
// Assumes cur_time counts up by one per clock.
module rfs_due_tracker #(
    parameter int TW     = 32,
    parameter int T_RP   = 4,
    parameter int T_RFC  = 20,
    parameter int T_REFI = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] cur_time,
    input  logic          advance,
    output logic          due_hit,
    output logic          overrun
);

    localparam logic [TW-1:0] RP_W   = TW'(T_RP);
    localparam logic [TW-1:0] RFC_W  = TW'(T_RFC);
    localparam logic [TW-1:0] REFI_W = TW'(T_REFI);

    logic [TW-1:0] due_q;
    logic [TW-1:0] due_next;

    assign due_next = due_q + REFI_W;

    // Start hint: leave room for a precharge before the due time.
    assign due_hit = (cur_time >= (due_q - RP_W));

    // Due-time register and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            due_q   <= REFI_W;
            overrun <= 1'b0;
        end else if (advance) begin
            due_q <= due_next;
            if (due_next < (cur_time + RFC_W)) begin
                overrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rfs_phase_ctrl.sv
// Module: rfs_phase_ctrl
// Phase FSM: wake, drain, precharge-all, refresh, release. Every output
// is registered; ref_go is the combinational refresh decision that the
// due tracker uses to advance its due time.
// Assumes cur_time counts up by one per clock and T_RP, T_RFC >= 1.
module rfs_phase_ctrl
    import rfs_pkg::*;
#(
    parameter int TW    = 32,
    parameter int BCW   = 4,
    parameter int T_RP  = 4,
    parameter int T_RFC = 20,
    parameter int T_XP  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  cur_time,
    input  logic           due_hit,
    input  logic           low_power,
    input  logic           drain_done,
    input  logic [BCW-1:0] active_banks,
    input  logic [TW-1:0]  latest_pre,
    output logic           ref_go,
    output logic           wake_req,
    output logic           prea_cmd,
    output logic           ref_cmd,
    output logic [TW-1:0]  act_floor,
    output logic           act_floor_upd,
    output logic           rank_busy
);

    localparam logic [TW-1:0] RP_W  = TW'(T_RP);
    localparam logic [TW-1:0] RFC_W = TW'(T_RFC);
    localparam logic [TW-1:0] XP_W  = TW'(T_XP);

    rfs_phase_e    phase_q;
    logic [TW-1:0] mark_q;
    logic          any_open;
    logic          drain_ok;
    logic          reached;

    assign any_open = (active_banks != '0);
    assign drain_ok = (phase_q == PH_DRAIN) && drain_done;
    assign reached  = (cur_time >= mark_q);

    // Refresh decision: drained with all banks closed, or precharge settled.
    assign ref_go = (drain_ok && !any_open) || ((phase_q == PH_SETTLE) && reached);

    // Phase progression, deadline tracking and command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q       <= PH_IDLE;
            mark_q        <= '0;
            wake_req      <= 1'b0;
            prea_cmd      <= 1'b0;
            ref_cmd       <= 1'b0;
            act_floor     <= '0;
            act_floor_upd <= 1'b0;
            rank_busy     <= 1'b0;
        end else begin
            wake_req      <= 1'b0;
            prea_cmd      <= 1'b0;
            ref_cmd       <= 1'b0;
            act_floor_upd <= 1'b0;
            if (ref_go) begin
                ref_cmd       <= 1'b1;
                act_floor     <= cur_time + RFC_W;
                act_floor_upd <= 1'b1;
                mark_q        <= cur_time + RFC_W;
                phase_q       <= PH_RUN;
            end else begin
                unique case (phase_q)
                    PH_IDLE: begin
                        if (due_hit) begin
                            rank_busy <= 1'b1;
                            if (low_power) begin
                                wake_req <= 1'b1;
                                mark_q   <= cur_time + XP_W;
                                phase_q  <= PH_WAKE;
                            end else begin
                                phase_q <= PH_DRAIN;
                            end
                        end
                    end
                    PH_WAKE: begin
                        if (reached) begin
                            phase_q <= PH_DRAIN;
                        end
                    end
                    PH_DRAIN: begin
                        if (drain_ok) begin
                            if (latest_pre <= cur_time) begin
                                prea_cmd      <= 1'b1;
                                act_floor     <= cur_time + RP_W;
                                act_floor_upd <= 1'b1;
                                mark_q        <= cur_time + RP_W;
                                phase_q       <= PH_SETTLE;
                            end else begin
                                mark_q  <= latest_pre;
                                phase_q <= PH_PRE;
                            end
                        end
                    end
                    PH_PRE: begin
                        if (reached) begin
                            prea_cmd      <= 1'b1;
                            act_floor     <= mark_q + RP_W;
                            act_floor_upd <= 1'b1;
                            mark_q        <= mark_q + RP_W;
                            phase_q       <= PH_SETTLE;
                        end
                    end
                    PH_SETTLE: begin
                        phase_q <= PH_SETTLE;
                    end
                    PH_RUN: begin
                        if (reached) begin
                            rank_busy <= 1'b0;
                            phase_q   <= PH_IDLE;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rank_refresh_seq.sv
// Module: rank_refresh_seq
// Per-rank refresh sequencer top: ties the due tracker, the bank
// precharge-time reduction and the phase FSM together and reports a
// parameter consistency flag.
// Assumes cur_time counts up by one per clock and never wraps in use.
module rank_refresh_seq #(
    parameter int TW     = 32,
    parameter int NB     = 8,
    parameter int BCW    = $clog2(NB + 1),
    parameter int T_RP   = 4,
    parameter int T_RFC  = 20,
    parameter int T_REFI = 200,
    parameter int T_XP   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  cur_time,
    input  logic [BCW-1:0] active_banks,
    input  logic [NB*TW-1:0] bank_pre_ok,
    input  logic           low_power,
    input  logic           drain_done,
    output logic           wake_req,
    output logic           prea_cmd,
    output logic           ref_cmd,
    output logic [TW-1:0]  act_floor,
    output logic           act_floor_upd,
    output logic           rank_busy,
    output logic           overrun_err,
    output logic           cfg_err
);

    localparam bit CFG_BAD = (T_REFI <= T_RP) || (T_REFI <= T_RFC);

    logic          due_hit;
    logic          ref_go;
    logic [TW-1:0] latest_pre;

    // Parameter consistency: the interval must exceed both precharge and refresh.
    assign cfg_err = CFG_BAD;

    rfs_latest_time #(
        .TW(TW),
        .NB(NB)
    ) latest_i (
        .times (bank_pre_ok),
        .latest(latest_pre)
    );

    rfs_due_tracker #(
        .TW    (TW),
        .T_RP  (T_RP),
        .T_RFC (T_RFC),
        .T_REFI(T_REFI)
    ) due_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_time(cur_time),
        .advance (ref_go),
        .due_hit (due_hit),
        .overrun (overrun_err)
    );

    rfs_phase_ctrl #(
        .TW   (TW),
        .BCW  (BCW),
        .T_RP (T_RP),
        .T_RFC(T_RFC),
        .T_XP (T_XP)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cur_time     (cur_time),
        .due_hit      (due_hit),
        .low_power    (low_power),
        .drain_done   (drain_done),
        .active_banks (active_banks),
        .latest_pre   (latest_pre),
        .ref_go       (ref_go),
        .wake_req     (wake_req),
        .prea_cmd     (prea_cmd),
        .ref_cmd      (ref_cmd),
        .act_floor    (act_floor),
        .act_floor_upd(act_floor_upd),
        .rank_busy    (rank_busy)
    );

endmodule

// File: rtl/rank_refresh_seq_chk.sv
// Module: rank_refresh_seq_chk
// Cycle-level properties of the refresh sequencer, bound to its top.
module rank_refresh_seq_chk #(
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] cur_time,
    input logic          wake_req,
    input logic          prea_cmd,
    input logic          ref_cmd,
    input logic [TW-1:0] act_floor,
    input logic          act_floor_upd,
    input logic          rank_busy,
    input logic          overrun_err
);

    // R12
    cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wake_req, prea_cmd, ref_cmd}) <= 1);

    // R12
    cmd_under_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req || prea_cmd || ref_cmd) |-> rank_busy);

    // R12
    prea_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prea_cmd |=> !prea_cmd);

    // R12
    ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> !ref_cmd);

    // R8
    busy_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> rank_busy);

    // R8
    floor_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> (act_floor_upd && (act_floor >= cur_time)));

    // R6
    floor_with_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_floor_upd |-> (prea_cmd || ref_cmd));

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |=> overrun_err);

endmodule

bind rank_refresh_seq rank_refresh_seq_chk #(.TW(TW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cur_time     (cur_time),
    .wake_req     (wake_req),
    .prea_cmd     (prea_cmd),
    .ref_cmd      (ref_cmd),
    .act_floor    (act_floor),
    .act_floor_upd(act_floor_upd),
    .rank_busy    (rank_busy),
    .overrun_err  (overrun_err)
);

// File: tb/rank_refresh_seq_tb_top.sv
// Scoreboard bench: the driver pushes predicted events, the monitor pops
// and compares them against the pulses the sequencer produces.
module rank_refresh_seq_tb_top;

    localparam int TW = 32;
    localparam int NB = 8;
    localparam int BCW = $clog2(NB + 1);

    typedef enum int { EV_WAKE, EV_PREA, EV_REF, EV_FLOOR } ev_kind_e;

    typedef struct {
        ev_kind_e kind;
        int       t;
        int       val;
        string    req;
    } ev_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TW-1:0]    cur_time = '0;
    logic [BCW-1:0]   active_banks = '0;
    logic [NB*TW-1:0] bank_pre_ok = '0;
    logic             low_power = 1'b0;
    logic             drain_done = 1'b1;
    logic             wake_req, prea_cmd, ref_cmd, act_floor_upd;
    logic             rank_busy, overrun_err, cfg_err;
    logic [TW-1:0]    act_floor;

    int  total = 0;
    int  bad = 0;
    ev_t exp_q[$];

    always #10 clk = ~clk;

    rank_refresh_seq #(
        .TW(TW), .NB(NB), .T_RP(4), .T_RFC(20), .T_REFI(200), .T_XP(3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cur_time(cur_time),
        .active_banks(active_banks), .bank_pre_ok(bank_pre_ok),
        .low_power(low_power), .drain_done(drain_done),
        .wake_req(wake_req), .prea_cmd(prea_cmd), .ref_cmd(ref_cmd),
        .act_floor(act_floor), .act_floor_upd(act_floor_upd),
        .rank_busy(rank_busy), .overrun_err(overrun_err), .cfg_err(cfg_err)
    );

    // Records one comparison.
    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Predicts one event.
    task automatic expect_ev(ev_kind_e k, int t, int v, string req);
        ev_t e;
        e.kind = k; e.t = t; e.val = v; e.req = req;
        exp_q.push_back(e);
    endtask

    // Advances the cycle count to T; inputs set afterwards apply at edge T.
    task automatic step_to(int t);
        while (int'(cur_time) < t) begin
            @(negedge clk);
            cur_time = cur_time + 1;
        end
    endtask

    // Moves to the sample point after the edge where cur_time equals T.
    task automatic sample_at(int t);
        step_to(t);
        @(posedge clk);
        #5;
    endtask

    // Compares one observed pulse with the head of the prediction queue.
    task automatic observe(ev_kind_e k, int v);
        ev_t e;
        if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R12 unexpected event %s at t=%0d actual=1 expected=0",
                     k.name(), cur_time);
        end else begin
            e = exp_q.pop_front();
            check(e.req, "event kind", int'(k), int'(e.kind));
            check(e.req, "event time", int'(cur_time), e.t);
            if (k == EV_FLOOR) check(e.req, "act_floor", v, e.val);
        end
    endtask

    // Monitor: watches the command pulses after every edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n) begin
                if (wake_req)      observe(EV_WAKE, 0);
                if (prea_cmd)      observe(EV_PREA, 0);
                if (ref_cmd)       observe(EV_REF, 0);
                if (act_floor_upd) observe(EV_FLOOR, int'(act_floor));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Driver: scenarios and their predicted schedules.
    initial begin
        sample_at(2);
        // R1 reset state
        check("R1", "busy in reset", int'(rank_busy), 0);
        check("R1", "pulses in reset", int'({wake_req, prea_cmd, ref_cmd, act_floor_upd}), 0);
        check("R1", "overrun in reset", int'(overrun_err), 0);
        // R11 consistent defaults
        check("R11", "cfg_err", int'(cfg_err), 0);
        step_to(5);
        rst_n = 1'b1;

        // Scenario 1 (R2, R7, R8): no open bank, first refresh at due 200.
        expect_ev(EV_REF, 197, 0, "R7");
        expect_ev(EV_FLOOR, 197, 217, "R8");
        sample_at(195);
        check("R2", "busy before trigger", int'(rank_busy), 0);
        sample_at(196);
        check("R2", "busy at trigger", int'(rank_busy), 1);
        sample_at(216);
        check("R8", "busy before end", int'(rank_busy), 1);
        sample_at(217);
        check("R8", "busy at end", int'(rank_busy), 0);

        // Scenario 2 (R5, R6, R9): precharge waits for the latest bank.
        step_to(300);
        active_banks = 3;
        for (int b = 0; b < NB; b++) bank_pre_ok[b*TW +: TW] = 100;
        bank_pre_ok[2*TW +: TW] = 403;
        bank_pre_ok[5*TW +: TW] = 405;
        expect_ev(EV_PREA, 405, 0, "R5");
        expect_ev(EV_FLOOR, 405, 409, "R6");
        expect_ev(EV_REF, 409, 0, "R6");
        expect_ev(EV_FLOOR, 409, 429, "R8");
        sample_at(395);
        check("R9", "busy before second trigger", int'(rank_busy), 0);
        sample_at(396);
        check("R9", "busy at second trigger", int'(rank_busy), 1);
        sample_at(429);
        check("R8", "busy after precharged refresh", int'(rank_busy), 0);

        // Scenario 3 (R5): bank times already past, precharge at drain check.
        step_to(450);
        active_banks = 2;
        for (int b = 0; b < NB; b++) bank_pre_ok[b*TW +: TW] = 500;
        bank_pre_ok[0*TW +: TW] = 590;
        expect_ev(EV_PREA, 597, 0, "R5");
        expect_ev(EV_FLOOR, 597, 601, "R6");
        expect_ev(EV_REF, 601, 0, "R6");
        expect_ev(EV_FLOOR, 601, 621, "R8");
        sample_at(621);
        check("R8", "busy after third refresh", int'(rank_busy), 0);

        // Scenario 4 (R3): wake-up before draining.
        step_to(700);
        active_banks = 0;
        low_power = 1'b1;
        expect_ev(EV_WAKE, 796, 0, "R3");
        expect_ev(EV_REF, 800, 0, "R3");
        expect_ev(EV_FLOOR, 800, 820, "R8");
        step_to(810);
        low_power = 1'b0;
        sample_at(820);
        check("R3", "busy after woken refresh", int'(rank_busy), 0);

        // Scenario 5 (R4): refresh held until requests drain.
        step_to(900);
        drain_done = 1'b0;
        expect_ev(EV_REF, 1010, 0, "R4");
        expect_ev(EV_FLOOR, 1010, 1030, "R8");
        sample_at(1005);
        check("R4", "busy while draining", int'(rank_busy), 1);
        step_to(1010);
        drain_done = 1'b1;
        sample_at(1030);
        check("R4", "busy after drained refresh", int'(rank_busy), 0);

        // Scenario 6 (R10): a long drain pushes the refresh past its window.
        step_to(1100);
        drain_done = 1'b0;
        expect_ev(EV_REF, 1400, 0, "R10");
        expect_ev(EV_FLOOR, 1400, 1420, "R10");
        sample_at(1390);
        check("R10", "overrun before late refresh", int'(overrun_err), 0);
        step_to(1400);
        drain_done = 1'b1;
        sample_at(1400);
        check("R10", "overrun after late refresh", int'(overrun_err), 1);
        sample_at(1410);
        check("R10", "overrun stays set", int'(overrun_err), 1);
        check("R12", "pending predictions", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule